// File: doc/BRIEF.md
# Debug Memory-Access Sequencer

This block turns single high-level debug requests into the exact byte sequence that a target's two-wire debug port expects. A request can read or write one external-data byte, read one code byte, read the status or configuration, write the configuration, fetch the chip identity, get or set the program counter, halt, resume, single-step, or erase the chip. Memory is never reached by a direct bus access. Instead, the block injects short CPU instructions through a length-coded debug-instruction command and reads the reply that the target returns after each one.

Below the block sits a byte-level master that moves one byte per handshake. On each transaction the block states whether the master must send a byte or clock one in. It keeps the byte and the direction steady until the master acknowledges. When the last transaction of a request is acknowledged, the block drops busy, pulses done for one cycle and presents the 16-bit result.

Top module: `dbg_mem_seq`

## Requirements
- R1: During and after reset, with no request accepted, busy, done and mst_req are low and result is zero.
- R2: When idle, a request with cmd_valid high and cmd_op in 0..12 is accepted and raises busy in the next cycle. Op encoding: 0 ext read, 1 ext write, 2 code read, 3 status, 4 chip ID, 5 get PC, 6 set PC, 7 halt, 8 resume, 9 step, 10 chip erase, 11 write config, 12 read config. Op codes 13 to 15 are ignored, and busy stays low.
- R3: A request presented while busy is ignored. The byte stream of the request in progress does not change, and no extra request is queued.
- R4: mst_req is high exactly while busy. mst_rd and mst_byte hold steady until mst_ack, and each mst_ack completes one transaction.
- R5: An injected instruction is framed as the byte 0x54 plus its length (1 to 3), then its instruction bytes written, then one reply read.
- R6: Ext read of address A issues instruction 0x90,A[15:8],A[7:0], then instruction 0xE0. The second reply becomes result[7:0], with result[15:8] zero.
- R7: Ext write of value V to address A issues 0x90,A[15:8],A[7:0], then 0x74,V, then 0xF0. Result is zero.
- R8: Code read of address A first issues 0x75,0xC7,(A>>15)*16+1 (0x01 or 0x11). It then issues 0x90,A[15:8],A[7:0], then 0xE4, then 0x93. The final reply is result[7:0].
- R9: Status 0x3F, read config 0x24, halt 0x44, resume 0x4C, step 0x5C and chip erase 0x14 each write their code byte and then read one reply, which becomes result[7:0].
- R10: Write config writes 0x1D, then the cmd_data byte, then reads one reply into result[7:0].
- R11: Chip ID (0x68) and get PC (0x28) write the code and then read two replies. The first reply becomes result[15:8] and the second becomes result[7:0].
- R12: Set PC writes 0x02, then address high byte, then address low byte, then reads one reply into result[7:0].
- R13: Done is a one-cycle pulse in the cycle after the final acknowledge. Busy is low in that cycle, result is valid, and a new request can be accepted in that same cycle.
- R14: Replies that are discarded are still read as full transactions, so every byte position is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request strobe |
| cmd_op | input | 4 | Request code |
| cmd_addr | input | 16 | Memory or PC address |
| cmd_data | input | 8 | Write value or configuration byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Result of the last request |
| mst_req | output | 1 | Transaction request to the byte master |
| mst_rd | output | 1 | 1 = clock in a reply byte, 0 = send mst_byte |
| mst_byte | output | 8 | Byte to send |
| mst_ack | input | 1 | Transaction complete |
| mst_rdata | input | 8 | Reply byte, valid with mst_ack on reads |

## Verification
Two events can fall in the same cycle: the completion of one request and the acceptance of the next. The bench holds cmd_valid high across several requests. Each request is then accepted in exactly the cycle its predecessor pulses done, and the presence held during busy must be dropped. The bench's model predicts busy, done and each transaction's direction and byte on every clock under varying acknowledge latency, including back-to-back acknowledges. Any early or doubled acceptance shows up as a byte-stream or busy mismatch.

// File: rtl/dbg_mem_seq.sv
module dbg_mem_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [3:0]  cmd_op,
  input  logic [15:0] cmd_addr,
  input  logic [7:0]  cmd_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] result,
  output logic        mst_req,
  output logic        mst_rd,
  output logic [7:0]  mst_byte,
  input  logic        mst_ack,
  input  logic [7:0]  mst_rdata
);
  localparam logic [3:0] OP_XRD = 4'd0, OP_XWR = 4'd1, OP_CRD = 4'd2, OP_STAT = 4'd3,
                         OP_ID = 4'd4, OP_GPC = 4'd5, OP_SPC = 4'd6, OP_HALT = 4'd7,
                         OP_RES = 4'd8, OP_STEP = 4'd9, OP_ERASE = 4'd10, OP_WCFG = 4'd11,
                         OP_RCFG = 4'd12;

  // step word: {last, read, capture, byte}
  localparam logic [10:0] RD_SKIP = 11'h200, RD_CAP = 11'h300,
                          END_CAP = 11'h700, END_SKIP = 11'h600;

  logic [3:0]  op_q, st_q;
  logic [15:0] addr_q;
  logic [7:0]  data_q;
  logic        s_last, s_rd, s_cap;
  logic [7:0]  s_byte;

  function automatic logic [10:0] wr(input logic [7:0] b);
    wr = {3'b000, b};
  endfunction

  function automatic logic [7:0] di(input logic [1:0] len);
    di = 8'h54 + {6'b0, len};
  endfunction

  function automatic logic [10:0] step_info(input logic [3:0] op, input logic [3:0] st,
                                            input logic [15:0] a, input logic [7:0] d);
    logic [7:0] bk;
    bk = {3'b000, a[15], 4'b0001};
    step_info = END_CAP;
    case (op)
      OP_XRD: case (st)
        4'd0: step_info = wr(di(2'd3));
        4'd1: step_info = wr(8'h90);
        4'd2: step_info = wr(a[15:8]);
        4'd3: step_info = wr(a[7:0]);
        4'd4: step_info = RD_SKIP;
        4'd5: step_info = wr(di(2'd1));
        4'd6: step_info = wr(8'hE0);
        default: step_info = END_CAP;
      endcase
      OP_XWR: case (st)
        4'd0: step_info = wr(di(2'd3));
        4'd1: step_info = wr(8'h90);
        4'd2: step_info = wr(a[15:8]);
        4'd3: step_info = wr(a[7:0]);
        4'd4: step_info = RD_SKIP;
        4'd5: step_info = wr(di(2'd2));
        4'd6: step_info = wr(8'h74);
        4'd7: step_info = wr(d);
        4'd8: step_info = RD_SKIP;
        4'd9: step_info = wr(di(2'd1));
        4'd10: step_info = wr(8'hF0);
        default: step_info = END_SKIP;
      endcase
      OP_CRD: case (st)
        4'd0: step_info = wr(di(2'd3));
        4'd1: step_info = wr(8'h75);
        4'd2: step_info = wr(8'hC7);
        4'd3: step_info = wr(bk);
        4'd4: step_info = RD_SKIP;
        4'd5: step_info = wr(di(2'd3));
        4'd6: step_info = wr(8'h90);
        4'd7: step_info = wr(a[15:8]);
        4'd8: step_info = wr(a[7:0]);
        4'd9: step_info = RD_SKIP;
        4'd10: step_info = wr(di(2'd1));
        4'd11: step_info = wr(8'hE4);
        4'd12: step_info = RD_SKIP;
        4'd13: step_info = wr(di(2'd1));
        4'd14: step_info = wr(8'h93);
        default: step_info = END_CAP;
      endcase
      OP_ID, OP_GPC: case (st)
        4'd0: step_info = wr(op == OP_ID ? 8'h68 : 8'h28);
        4'd1: step_info = RD_CAP;
        default: step_info = END_CAP;
      endcase
      OP_SPC: case (st)
        4'd0: step_info = wr(8'h02);
        4'd1: step_info = wr(a[15:8]);
        4'd2: step_info = wr(a[7:0]);
        default: step_info = END_CAP;
      endcase
      OP_WCFG: case (st)
        4'd0: step_info = wr(8'h1D);
        4'd1: step_info = wr(d);
        default: step_info = END_CAP;
      endcase
      default: case (st)
        4'd0: case (op)
          OP_STAT:  step_info = wr(8'h3F);
          OP_HALT:  step_info = wr(8'h44);
          OP_RES:   step_info = wr(8'h4C);
          OP_STEP:  step_info = wr(8'h5C);
          OP_ERASE: step_info = wr(8'h14);
          default:  step_info = wr(8'h24);
        endcase
        default: step_info = END_CAP;
      endcase
    endcase
  endfunction

  assign {s_last, s_rd, s_cap, s_byte} = step_info(op_q, st_q, addr_q, data_q);
  assign mst_req  = busy;
  assign mst_rd   = s_rd;
  assign mst_byte = s_byte;

  wire legal = cmd_op <= OP_RCFG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      op_q   <= '0;
      st_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid && legal) begin
          busy   <= 1'b1;
          op_q   <= cmd_op;
          addr_q <= cmd_addr;
          data_q <= cmd_data;
          st_q   <= '0;
          result <= '0;
        end
      end else if (mst_ack) begin
        if (s_rd && s_cap) result <= {result[7:0], mst_rdata};
        if (s_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          st_q <= st_q + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/dbg_mem_seq_chk.sv
module dbg_mem_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       mst_req,
  input logic       mst_rd,
  input logic [7:0] mst_byte,
  input logic       mst_ack
);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op <= 4'd12) |=> busy);
  assert_bad_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_valid && cmd_op <= 4'd12)) |=> !busy);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && !mst_ack) |=> ($stable(mst_byte) && $stable(mst_rd)));
  assert_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_after_ack_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mst_ack));
endmodule

bind dbg_mem_seq dbg_mem_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .done(done), .mst_req(mst_req), .mst_rd(mst_rd),
  .mst_byte(mst_byte), .mst_ack(mst_ack)
);

// File: tb/tb_dbg_mem_seq.sv
`timescale 1ns/1ps
module tb_dbg_mem_seq;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [3:0] cmd_op = 0;
  logic [15:0] cmd_addr = 0;
  logic [7:0] cmd_data = 0;
  logic busy, done, mst_req, mst_rd, mst_ack = 0;
  logic [15:0] result;
  logic [7:0] mst_byte, mst_rdata = 0;

  dbg_mem_seq dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .done(done), .result(result),
    .mst_req(mst_req), .mst_rd(mst_rd), .mst_byte(mst_byte), .mst_ack(mst_ack),
    .mst_rdata(mst_rdata));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit mon_en = 0, ended = 0;
  string cur_tag = "R1";
  logic [9:0] expq[$];   // {capture, read, byte}
  logic [9:0] e;
  logic m_busy = 0, m_done = 0, nb, nd;
  logic [15:0] m_result = 0, acc = 0;
  int wait_n = 0, lat_k = 0, rd_k = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pw(input logic [7:0] b); expq.push_back({2'b00, b}); endtask
  task automatic pr(input logic c); expq.push_back({c, 1'b1, 8'h00}); endtask

  // expected stream per request, from the requirements (R5..R12)
  task automatic build(input logic [3:0] op, input logic [15:0] a, input logic [7:0] d);
    case (op)
      0: begin pw(8'h57); pw(8'h90); pw(a[15:8]); pw(a[7:0]); pr(0); pw(8'h55); pw(8'hE0); pr(1); end
      1: begin pw(8'h57); pw(8'h90); pw(a[15:8]); pw(a[7:0]); pr(0);
               pw(8'h56); pw(8'h74); pw(d); pr(0); pw(8'h55); pw(8'hF0); pr(0); end
      2: begin pw(8'h57); pw(8'h75); pw(8'hC7); pw(a[15] ? 8'h11 : 8'h01); pr(0);
               pw(8'h57); pw(8'h90); pw(a[15:8]); pw(a[7:0]); pr(0);
               pw(8'h55); pw(8'hE4); pr(0); pw(8'h55); pw(8'h93); pr(1); end
      3: begin pw(8'h3F); pr(1); end
      4: begin pw(8'h68); pr(1); pr(1); end
      5: begin pw(8'h28); pr(1); pr(1); end
      6: begin pw(8'h02); pw(a[15:8]); pw(a[7:0]); pr(1); end
      7: begin pw(8'h44); pr(1); end
      8: begin pw(8'h4C); pr(1); end
      9: begin pw(8'h5C); pr(1); end
      10: begin pw(8'h14); pr(1); end
      11: begin pw(8'h1D); pw(d); pr(1); end
      default: begin pw(8'h24); pr(1); end
    endcase
  endtask

  // master responder and reference model, evaluated mid-cycle
  initial forever begin
    @(negedge clk);
    if (mon_en) begin
      chk(busy === m_busy, {"R2 R3 busy ", cur_tag}, busy, m_busy);
      chk(done === m_done, "R13 done", done, m_done);
      if (m_done) chk(result === m_result, {cur_tag, " result"}, result, m_result);
      chk(mst_req === m_busy, "R4 req", mst_req, m_busy);
      nb = m_busy; nd = 0;
      if (m_busy && expq.size() > 0) begin
        if (wait_n > 0) begin
          wait_n--; mst_ack = 0;
        end else begin
          e = expq.pop_front();
          chk({mst_rd, mst_byte} === e[8:0], {"R5 R14 ", cur_tag, " byte"}, {mst_rd, mst_byte}, e[8:0]);
          mst_ack = 1;
          if (e[8]) begin
            mst_rdata = 8'h3C + 8'(rd_k * 29); rd_k++;
            if (e[9]) acc = {acc[7:0], mst_rdata};
          end
          wait_n = lat_k % 4; lat_k++;
          if (expq.size() == 0) begin nb = 0; nd = 1; m_result = acc; end
        end
      end else mst_ack = 0;
      if (!m_busy && cmd_valid && cmd_op <= 4'd12) begin
        build(cmd_op, cmd_addr, cmd_data);
        nb = 1; acc = 0; wait_n = lat_k % 3; lat_k++;
      end
      m_busy = nb; m_done = nd;
    end
  end

  task automatic summary;
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic run(input logic [3:0] op, input logic [15:0] a, input logic [7:0] d, input string tag);
    while (busy) tick();
    cur_tag = tag; cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    tick();
    cmd_valid = 0;
    do tick(); while (!done);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) tick();
    @(negedge clk);
    chk(busy === 0 && done === 0 && mst_req === 0, "R1 reset outputs", {busy, done, mst_req}, 0);
    rst_n = 1;
    tick(); @(negedge clk);
    chk(busy === 0 && done === 0 && mst_req === 0 && result === 0, "R1 after reset", result, 0);
    tick();
    mon_en = 1;
    tick();
    run(0, 16'h1234, 0, "R6");
    run(0, 16'hF0FF, 0, "R6");
    run(1, 16'hF000, 8'hA7, "R7");
    run(2, 16'h0456, 0, "R8");
    run(2, 16'h8123, 0, "R8");
    run(3, 0, 0, "R9");
    run(7, 0, 0, "R9");
    run(8, 0, 0, "R9");
    run(9, 0, 0, "R9");
    run(10, 0, 0, "R9");
    run(12, 0, 0, "R9");
    run(11, 0, 8'h5B, "R10");
    run(4, 0, 0, "R11");
    run(5, 0, 0, "R11");
    run(6, 16'hBEEF, 0, "R12");
    // undefined codes leave the block idle (R2)
    cur_tag = "R2";
    for (int k = 13; k < 16; k++) begin
      cmd_valid = 1; cmd_op = 4'(k); tick();
      cmd_valid = 0; tick();
      @(negedge clk); chk(busy === 0 && mst_req === 0, "R2 undefined op ignored", busy, 0);
      tick();
    end
    // requests while busy are dropped (R3)
    cur_tag = "R3";
    cmd_valid = 1; cmd_op = 0; cmd_addr = 16'h2222; tick();
    cmd_op = 7; cmd_addr = 16'h9999; tick();
    tick(); tick();
    cmd_valid = 0;
    do tick(); while (!done);
    // held request: completion and acceptance in the same cycle (R13)
    cur_tag = "R13";
    cmd_valid = 1; cmd_op = 3;
    for (int k = 0; k < 3; k++) begin
      do tick(); while (!done);
    end
    cmd_valid = 0;
    cmd_op = 4;
    while (busy) tick();
    repeat (4) tick();
    summary();
  end
endmodule